// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each of the two ALU operands of the instruction now in the execute stage, where that operand's value comes from. An operand comes from the register file, from the result held one stage ahead in the execute-to-memory register, or from the result held two stages ahead in the memory-to-writeback register. An older instruction that has computed a value but not yet written it back can then feed a dependent instruction right away, without a stall. The select logic is purely combinational. It compares the 5-bit source register numbers against the destination number and write flag of each later stage.

A thin wrapper around the select logic holds the two downstream pipeline registers, the two operand muxes, the immediate substitution on the second operand and a plain adder. With these parts the selects can be checked by the values they deliver. The register file itself lies outside the block. Its read data arrives on input ports, and committed results leave on the writeback port.

Top module: `exec_fwd_path`

## Requirements
- R1: Each 2-bit operand select uses 2'b00 for register-file data, 2'b10 for the execute-to-memory result and 2'b01 for the memory-to-writeback result; 2'b11 never appears, and the delivered operand equals the value the select names.
- R2: Operand A selects 2'b10 when the instruction one cycle older has its write flag set, a nonzero destination, and a destination equal to source A.
- R3: Operand B follows the rule of R2, compared against source B.
- R4: An operand selects 2'b01 when the instruction two cycles older has its write flag set, a nonzero destination equal to the source, and the instruction one cycle older does not forward to it under R2/R3.
- R5: When both older instructions write the register being read, the newer (execute-to-memory) result is chosen.
- R6: Register 0 is never forwarded: a source of 0 always selects 2'b00, even when an older instruction has its write flag set with destination 0.
- R7: With the immediate flag set, operand B is the 16-bit immediate sign-extended to 32 bits, taken after the forwarding mux; the reported B select is unchanged.
- R8: The sum of the two operands appears on the writeback port two cycles after issue, with the issuing instruction's write flag and destination.
- R9: During and right after reset, both pipeline registers hold a cleared write flag, so no operand is forwarded and the writeback port is idle.
- R10: Three back-to-back adds that each read and write the same register each see the latest value of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_src_a | input | 5 | Source register number of operand A |
| ex_src_b | input | 5 | Source register number of operand B |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes its destination |
| ex_use_imm | input | 1 | Operand B takes the immediate |
| ex_imm | input | 16 | Immediate value, sign-extended for operand B |
| ex_rf_a | input | 32 | Register-file read data for operand A |
| ex_rf_b | input | 32 | Register-file read data for operand B |
| sel_a | output | 2 | Forwarding select of operand A |
| sel_b | output | 2 | Forwarding select of operand B |
| ex_opnd_a | output | 32 | Operand A as delivered to the ALU |
| ex_opnd_b | output | 32 | Operand B as delivered to the ALU, after the immediate mux |
| ex_result | output | 32 | Sum of the two operands |
| wb_wr | output | 1 | Writeback write flag |
| wb_dst | output | 5 | Writeback destination register |
| wb_data | output | 32 | Writeback data |

## Verification
The bench builds the block with its default widths: 5-bit register numbers, 32-bit data and a 16-bit immediate. The register space is small enough that one sweep walks every source against every destination of the preceding instruction. A second long run draws all register numbers from 0 to 3, so double hits, writes to register 0 and masked writes recur often. An architectural register model, updated in program order, supplies the expected operand values. A second model updated only at writeback supplies the register-file read data, so any wrong select shows up as a wrong value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source codes; the operand mux decodes these values.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WBACK   = 2'b01,
    SRC_EXMEM   = 2'b10
  } fwd_src_e;

  localparam int unsigned N_OPND = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] rd_src,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             wbk_wr,
  input  logic [REG_W-1:0] wbk_dst,
  output logic [1:0]       sel
);

  logic exm_hit;
  logic wbk_hit;

  always_comb begin
    exm_hit = exm_wr && (exm_dst != '0) && (exm_dst == rd_src);
    wbk_hit = wbk_wr && (wbk_dst != '0) && (wbk_dst == rd_src);
    // The newer stage wins; the older hit only counts when the newer misses.
    if (exm_hit) begin
      sel = SRC_EXMEM;
    end else if (wbk_hit) begin
      sel = SRC_WBACK;
    end else begin
      sel = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NOPND = N_OPND
) (
  input  logic [NOPND-1:0][REG_W-1:0] rd_src,
  input  logic                        exm_wr,
  input  logic [REG_W-1:0]            exm_dst,
  input  logic                        wbk_wr,
  input  logic [REG_W-1:0]            wbk_dst,
  output logic [NOPND-1:0][1:0]       sel
);

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fwd_match #(
      .REG_W(REG_W)
    ) i_match (
      .rd_src (rd_src[g]),
      .exm_wr (exm_wr),
      .exm_dst(exm_dst),
      .wbk_wr (wbk_wr),
      .wbk_dst(wbk_dst),
      .sel    (sel[g])
    );
  end

endmodule

// File: rtl/opnd_sel.sv
module opnd_sel
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] wbk_val,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    unique case (fwd_src_e'(sel))
      SRC_EXMEM: opnd = exm_val;
      SRC_WBACK: opnd = wbk_val;
      default:   opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/exec_fwd_path.sv
module exec_fwd_path
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ex_src_a,
  input  logic [REG_W-1:0]  ex_src_b,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              ex_wr,
  input  logic              ex_use_imm,
  input  logic [IMM_W-1:0]  ex_imm,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] ex_opnd_a,
  output logic [DATA_W-1:0] ex_opnd_b,
  output logic [DATA_W-1:0] ex_result,
  output logic              wb_wr,
  output logic [REG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data
);

  localparam int unsigned EXT_W  = DATA_W - IMM_W;
  localparam int unsigned PIPE_W = 1 + REG_W + DATA_W;

  // Pipeline advances every cycle; the enable is kept explicit.
  logic pipe_adv;
  assign pipe_adv = 1'b1;

  logic [PIPE_W-1:0] exm_d, exm_q;
  logic [PIPE_W-1:0] wbk_q;

  logic              exm_wr;
  logic [REG_W-1:0]  exm_dst;
  logic [DATA_W-1:0] exm_data;
  logic              wbk_wr;
  logic [REG_W-1:0]  wbk_dst;
  logic [DATA_W-1:0] wbk_data;

  assign {exm_wr, exm_dst, exm_data} = exm_q;
  assign {wbk_wr, wbk_dst, wbk_data} = wbk_q;

  // Select generation
  logic [N_OPND-1:0][REG_W-1:0]  src_vec;
  logic [N_OPND-1:0][1:0]        sel_vec;
  logic [N_OPND-1:0][DATA_W-1:0] rf_vec;
  logic [N_OPND-1:0][DATA_W-1:0] fwd_vec;

  assign src_vec = {ex_src_b, ex_src_a};
  assign rf_vec  = {ex_rf_b, ex_rf_a};

  fwd_unit #(
    .REG_W(REG_W),
    .NOPND(N_OPND)
  ) i_fwd_unit (
    .rd_src (src_vec),
    .exm_wr (exm_wr),
    .exm_dst(exm_dst),
    .wbk_wr (wbk_wr),
    .wbk_dst(wbk_dst),
    .sel    (sel_vec)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_mux
    opnd_sel #(
      .DATA_W(DATA_W)
    ) i_opnd_sel (
      .sel    (sel_vec[g]),
      .rf_val (rf_vec[g]),
      .exm_val(exm_data),
      .wbk_val(wbk_data),
      .opnd   (fwd_vec[g])
    );
  end

  // Immediate substitution sits after the forwarding mux on operand B.
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b_fin;
  logic [DATA_W-1:0] sum;

  always_comb begin
    imm_ext    = {{EXT_W{ex_imm[IMM_W-1]}}, ex_imm};
    opnd_b_fin = ex_use_imm ? imm_ext : fwd_vec[1];
    sum        = fwd_vec[0] + opnd_b_fin;
  end

  // Execute-to-memory and memory-to-writeback registers
  assign exm_d = {ex_wr, ex_dst, sum};

  stage_reg #(
    .W(PIPE_W)
  ) i_exm_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pipe_adv),
    .d    (exm_d),
    .q    (exm_q)
  );

  stage_reg #(
    .W(PIPE_W)
  ) i_wbk_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pipe_adv),
    .d    (exm_q),
    .q    (wbk_q)
  );

  assign sel_a     = sel_vec[0];
  assign sel_b     = sel_vec[1];
  assign ex_opnd_a = fwd_vec[0];
  assign ex_opnd_b = opnd_b_fin;
  assign ex_result = sum;
  assign wb_wr     = wbk_wr;
  assign wb_dst    = wbk_dst;
  assign wb_data   = wbk_data;

endmodule

// File: rtl/exec_fwd_path_chk.sv
module exec_fwd_path_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  ex_src_a,
  input logic [REG_W-1:0]  ex_src_b,
  input logic [REG_W-1:0]  ex_dst,
  input logic              ex_wr,
  input logic              ex_use_imm,
  input logic [IMM_W-1:0]  ex_imm,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] ex_opnd_b,
  input logic [DATA_W-1:0] ex_result,
  input logic              wb_wr,
  input logic [REG_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_data
);

  // Edges seen since reset release, saturating at two.
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 2'd0;
    end else if (seen != 2'd2) begin
      seen <= seen + 2'd1;
    end
  end

  p_sel_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  p_exm_fwd_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0) && $past(ex_wr) && ($past(ex_dst) != '0) && ($past(ex_dst) == ex_src_a)
    |-> sel_a == 2'b10);

  p_exm_fwd_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0) && $past(ex_wr) && ($past(ex_dst) != '0) && ($past(ex_dst) == ex_src_b)
    |-> sel_b == 2'b10);

  p_wb_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2) && $past(ex_wr, 2) && ($past(ex_dst, 2) != '0) &&
    ($past(ex_dst, 2) == ex_src_a) && !($past(ex_wr) && ($past(ex_dst) == ex_src_a))
    |-> sel_a == 2'b01);

  p_newer_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0) && $past(ex_wr) && ($past(ex_dst) == ex_src_b) && (ex_src_b != '0)
    |-> sel_b != 2'b01);

  p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_src_a == '0) |-> (sel_a == 2'b00)) and ((ex_src_b == '0) |-> (sel_b == 2'b00)));

  p_imm_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_use_imm |-> ex_opnd_b == {{(DATA_W-IMM_W){ex_imm[IMM_W-1]}}, ex_imm});

  p_wb_pipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2) |-> (wb_wr == $past(ex_wr, 2)) && (wb_dst == $past(ex_dst, 2)) &&
                       (wb_data == $past(ex_result, 2)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r9: assert ((wb_wr == 1'b0) && (sel_a == 2'b00) && (sel_b == 2'b00));
    end
  end

endmodule

bind exec_fwd_path exec_fwd_path_chk #(
  .REG_W (REG_W),
  .DATA_W(DATA_W),
  .IMM_W (IMM_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ex_src_a  (ex_src_a),
  .ex_src_b  (ex_src_b),
  .ex_dst    (ex_dst),
  .ex_wr     (ex_wr),
  .ex_use_imm(ex_use_imm),
  .ex_imm    (ex_imm),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .ex_opnd_b (ex_opnd_b),
  .ex_result (ex_result),
  .wb_wr     (wb_wr),
  .wb_dst    (wb_dst),
  .wb_data   (wb_data)
);

// File: tb/test_exec_fwd_path.sv
module test_exec_fwd_path;

  logic        clk;
  logic        rst_n;
  logic [4:0]  ex_src_a, ex_src_b, ex_dst;
  logic        ex_wr, ex_use_imm;
  logic [15:0] ex_imm;
  logic [31:0] ex_rf_a, ex_rf_b;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] ex_opnd_a, ex_opnd_b, ex_result;
  logic        wb_wr;
  logic [4:0]  wb_dst;
  logic [31:0] wb_data;

  int n_chk = 0;
  int n_err = 0;

  exec_fwd_path i_exec_fwd_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .ex_dst    (ex_dst),
    .ex_wr     (ex_wr),
    .ex_use_imm(ex_use_imm),
    .ex_imm    (ex_imm),
    .ex_rf_a   (ex_rf_a),
    .ex_rf_b   (ex_rf_b),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .ex_opnd_a (ex_opnd_a),
    .ex_opnd_b (ex_opnd_b),
    .ex_result (ex_result),
    .wb_wr     (wb_wr),
    .wb_dst    (wb_dst),
    .wb_data   (wb_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // arch: updated in program order; rfm: updated only at writeback.
  logic [31:0] arch [32];
  logic [31:0] rfm  [32];
  // History: index 0 = one instruction older, 1 = two older.
  logic        h_wr  [2];
  logic [4:0]  h_dst [2];
  logic [31:0] h_res [2];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] want_sel(input logic [4:0] s);
    if (h_wr[0] && h_dst[0] != 5'd0 && h_dst[0] == s) return 2'b10;
    if (h_wr[1] && h_dst[1] != 5'd0 && h_dst[1] == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [4:0] s, input logic [1:0] e, input bit is_b);
    if (s == 5'd0) return "R6";
    if (e == 2'b10 && h_wr[1] && h_dst[1] == s) return "R5";
    if (e == 2'b10) return is_b ? "R3" : "R2";
    if (e == 2'b01) return "R4";
    return "R1";
  endfunction

  task automatic issue(input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] d,
                       input logic wr, input logic ui, input logic [15:0] imm,
                       input string rtag);
    logic [31:0] ea, eb, er, ext;
    logic [1:0]  esa, esb;
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb; ex_dst = d; ex_wr = wr;
    ex_use_imm = ui; ex_imm = imm;
    ex_rf_a = rfm[sa]; ex_rf_b = rfm[sb];
    ext = {{16{imm[15]}}, imm};
    ea  = arch[sa];
    eb  = ui ? ext : arch[sb];
    er  = ea + eb;
    esa = want_sel(sa);
    esb = want_sel(sb);
    #1;
    chk(sel_tag(sa, esa, 1'b0), "sel_a", {30'd0, sel_a}, {30'd0, esa});
    chk(sel_tag(sb, esb, 1'b1), "sel_b", {30'd0, sel_b}, {30'd0, esb});
    chk(rtag, "opnd_a", ex_opnd_a, ea);
    chk(ui ? "R7" : rtag, "opnd_b", ex_opnd_b, eb);
    chk(rtag, "result", ex_result, er);
    chk("R8", "wb_wr", {31'd0, wb_wr}, {31'd0, h_wr[1]});
    if (h_wr[1]) begin
      chk("R8", "wb_dst", {27'd0, wb_dst}, {27'd0, h_dst[1]});
      chk("R8", "wb_data", wb_data, h_res[1]);
    end
    // Register file commits the writeback-stage instruction at this edge.
    if (h_wr[1] && h_dst[1] != 5'd0) rfm[h_dst[1]] = h_res[1];
    if (wr && d != 5'd0) arch[d] = er;
    h_wr[1] = h_wr[0]; h_dst[1] = h_dst[0]; h_res[1] = h_res[0];
    h_wr[0] = wr;      h_dst[0] = d;        h_res[0] = er;
  endtask

  task automatic bubble();
    issue(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 16'd0, "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      arch[r] = (r == 0) ? 32'd0 : 32'(r) * 32'h0101_0017 + 32'd5;
      rfm[r]  = arch[r];
    end
    for (int k = 0; k < 2; k++) begin
      h_wr[k] = 1'b0; h_dst[k] = 5'd0; h_res[k] = 32'd0;
    end
    rst_n = 1'b0;
    ex_src_a = 5'd3; ex_src_b = 5'd3; ex_dst = 5'd3; ex_wr = 1'b0;
    ex_use_imm = 1'b0; ex_imm = 16'd0; ex_rf_a = 32'd0; ex_rf_b = 32'd0;
    repeat (3) @(negedge clk);
    // R9: reset state, nothing forwarded, writeback idle
    chk("R9", "sel_a in reset", {30'd0, sel_a}, 32'd0);
    chk("R9", "sel_b in reset", {30'd0, sel_b}, 32'd0);
    chk("R9", "wb_wr in reset", {31'd0, wb_wr}, 32'd0);
    rst_n = 1'b1;

    // R10: three dependent adds on r5, then a reader one slot later
    bubble(); bubble();
    issue(5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 16'd0, "R10");
    issue(5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 16'd0, "R10");
    issue(5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 16'd0, "R10");
    bubble();
    issue(5'd7, 5'd5, 5'd8, 1'b1, 1'b0, 16'd0, "R4");

    // R6: write to register 0 is not forwarded
    issue(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 16'd0, "R6");
    issue(5'd0, 5'd0, 5'd9, 1'b1, 1'b0, 16'd0, "R6");
    issue(5'd0, 5'd9, 5'd10, 1'b1, 1'b0, 16'd0, "R6");

    // R7: negative immediate replaces a forwarded operand B
    issue(5'd10, 5'd10, 5'd11, 1'b1, 1'b1, 16'h8001, "R7");
    issue(5'd11, 5'd11, 5'd12, 1'b1, 1'b1, 16'h7fff, "R7");

    // Full sweep: every source against every preceding destination
    for (int n = 0; n < 4096; n++) begin
      logic [31:0] v;
      v = 32'(n);
      issue(v[4:0], v[9:5] ^ v[4:0], v[9:5], v[10] | v[11], (n % 7) == 0,
            v[15:0] * 16'h3b, "R1");
    end

    // Crowded run on registers 0..3
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] h;
      h = 32'(n) * 32'h9e37_79b1;
      issue({3'd0, h[1:0]}, {3'd0, h[3:2]}, {3'd0, h[5:4]}, h[6] | h[7],
            h[10:8] == 3'd0, h[31:16], "R5");
    end

    bubble(); bubble(); bubble();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule